// File: doc/BRIEF.md
# Processor clock, ready and reset generator

This block takes two fast timing sources, a crystal-derived clock and an external frequency input, and picks one of them with a static select pin. From the chosen source it derives a processor clock at one third of the source rate, high for one source period and low for two. It also derives a peripheral clock at half the processor rate with an even duty cycle. The chosen source is passed straight back out so that further generators can be fed from it. A synchronization input holds both dividers at phase zero. When several generators release it on the same source edge, their divided clocks stay in step.

The block registers two more signals so that they change only on rising edges of the processor clock. The first is a wait request, built from two pairs of ready inputs, each pair qualified by its own active-low enable. The second is a processor reset, taken from an active-low reset request. The reset asserts on the first processor-clock edge after the request goes low. It releases only after the request has been seen high through a chain of synchronizing flops.

Top module: `cpu_clkgen`

## Requirements
- R1: `src_sel` = 0 selects `clk_xtal` and `src_sel` = 1 selects `clk_ext`. `osc_out` is a copy of the selected source, and every divided output is timed by its rising edges.
- R2: `cpu_clk` has a period of 3 source cycles and is high for exactly 1 of them. Its first rising edge comes on the first source edge at which `csync` is sampled low.
- R3: `per_clk` toggles only on rising edges of `cpu_clk`. Its first rising edge coincides with the first rising edge of `cpu_clk`, giving a period of 6 source cycles that is high for 3.
- R4: While `csync` is sampled high, the next source edge leaves `cpu_clk` = 0, `per_clk` = 0, `cpu_ready` = 0 and `cpu_rst` = 1.
- R5: On each rising edge of `cpu_clk`, `cpu_ready` takes the value 0 exactly when (`rdy_a` = 0 or `rdy_a_en_n` = 1) and (`rdy_b` = 0 or `rdy_b_en_n` = 1), using the inputs present just before that edge. In every other case it takes the value 1.
- R6: `cpu_ready` never changes on a source edge that is not a rising edge of `cpu_clk`. Input changes between processor edges therefore have no effect until the next processor edge.
- R7: `cpu_rst` is 1 after the first rising edge of `cpu_clk` at which `rst_req_n` was low.
- R8: `cpu_rst` returns to 0 only on a rising edge of `cpu_clk`. This happens on the second such edge at which `rst_req_n` has been sampled high in succession.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal-derived source clock |
| clk_ext | input | 1 | External frequency source clock |
| src_sel | input | 1 | Source select: 0 crystal, 1 external (static outside reset) |
| csync | input | 1 | Divider synchronization, high holds phase zero |
| rdy_a | input | 1 | Ready input of pair A |
| rdy_a_en_n | input | 1 | Active-low enable of pair A |
| rdy_b | input | 1 | Ready input of pair B |
| rdy_b_en_n | input | 1 | Active-low enable of pair B |
| rst_req_n | input | 1 | Active-low reset request |
| osc_out | output | 1 | Copy of the selected source |
| cpu_clk | output | 1 | Processor clock, source/3, 33% high |
| per_clk | output | 1 | Peripheral clock, source/6, 50% high |
| cpu_ready | output | 1 | Registered ready to the processor |
| cpu_rst | output | 1 | Registered processor reset, active high |

## Verification
The bench builds the block with its default parameters: a divide-by-three processor clock high for one source cycle, two ready pairs and a two-flop reset chain. With these values, one processor period covers the whole ready and reset behaviour within three source edges. The bench runs with each source selected in turn, with the two sources at periods of 20 ns and 14 ns. A divider fed from the wrong source would then drift against the bench's edge count. Directed passes walk all sixteen ready-input combinations. Random passes change inputs between processor edges and toggle the reset request, and each pass starts with a synchronization pulse so that realignment of the phase is checked as well.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
// Package clkgen_pkg
// Shared types and helpers for the processor clock generator.
// Assumes every ready pair is a ready level qualified by an active-low enable.
package clkgen_pkg;

    // One ready source and its active-low enable.
    typedef struct packed {
        logic rdy;
        logic en_n;
    } rdy_pair_t;

    // A pair asks for a wait when its ready is low or it is not enabled.
    function automatic logic pair_wants_wait(rdy_pair_t p);
        return (!p.rdy) || p.en_n;
    endfunction

endpackage

// File: rtl/clkgen_src_sel.sv
`timescale 1ns/1ps
// Module clkgen_src_sel
// Picks the timing source for the generator and buffers it out.
// Assumes sel only changes while the generator is held in reset, so a
// plain multiplexer is used and no glitch-free switching is attempted.
module clkgen_src_sel (
    input  logic clk_xtal,
    input  logic clk_ext,
    input  logic sel,
    output logic src_clk
);

    // Static source multiplexer.
    assign src_clk = sel ? clk_ext : clk_xtal;

endmodule

// File: rtl/clkgen_div.sv
`timescale 1ns/1ps
// Module clkgen_div
// Divides the source clock by DIV, with an output that is high for HIGH
// source cycles, and flags the source cycle that ends with a rising edge
// of the divided clock.
// Assumes 2 <= DIV and 1 <= HIGH < DIV. hold is an active-high
// synchronous clear to phase zero.
module clkgen_div #(
    parameter int DIV   = 3,
    parameter int HIGH  = 1,
    parameter int CNT_W = (DIV > 2) ? $clog2(DIV) : 1
) (
    input  logic src_clk,
    input  logic hold,
    output logic clk_out,
    output logic rise_en
);

    localparam logic [CNT_W-1:0] LAST   = CNT_W'(DIV - 1);
    localparam logic [CNT_W-1:0] HI_END = CNT_W'(HIGH);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    // Next phase: wrap after the last phase, park on the last phase while held.
    always_comb begin
        if (hold)
            cnt_nxt = LAST;
        else if (cnt_q == LAST)
            cnt_nxt = '0;
        else
            cnt_nxt = cnt_q + 1'b1;
    end

    // The divided clock rises when the counter wraps to phase zero.
    assign rise_en = !hold && (cnt_q == LAST);

    // Phase counter.
    always_ff @(posedge src_clk) begin
        cnt_q <= cnt_nxt;
    end

    // Registered clock output, decoded from the next phase so it has no glitches.
    always_ff @(posedge src_clk) begin
        if (hold)
            clk_out <= 1'b0;
        else
            clk_out <= (cnt_nxt < HI_END);
    end

endmodule

// File: rtl/clkgen_per.sv
`timescale 1ns/1ps
// Module clkgen_per
// Halves the processor clock by toggling on each of its rising edges,
// giving an even duty cycle.
// Assumes rise_en marks the source cycle in which the processor clock rises.
module clkgen_per (
    input  logic src_clk,
    input  logic hold,
    input  logic rise_en,
    output logic per_clk
);

    // Toggle flop, cleared low while held.
    always_ff @(posedge src_clk) begin
        if (hold)
            per_clk <= 1'b0;
        else if (rise_en)
            per_clk <= !per_clk;
    end

endmodule

// File: rtl/clkgen_ready.sv
`timescale 1ns/1ps
// Module clkgen_ready
// Combines NUM_PAIRS ready/enable pairs and registers the result on
// processor-clock rising edges. The output is low (wait) only when every
// pair asks for a wait.
// Assumes rise_en marks the processor-clock rising edge, and hold clears
// the output low.
module clkgen_ready
    import clkgen_pkg::*;
#(
    parameter int NUM_PAIRS = 2
) (
    input  logic                 src_clk,
    input  logic                 hold,
    input  logic                 rise_en,
    input  rdy_pair_t [NUM_PAIRS-1:0] pairs,
    output logic                 ready
);

    logic [NUM_PAIRS-1:0] pair_wait;

    // One wait vote per pair.
    for (genvar gi = 0; gi < NUM_PAIRS; gi++) begin : g_pair
        assign pair_wait[gi] = pair_wants_wait(pairs[gi]);
    end

    // Ready register, updated only on processor-clock rising edges.
    always_ff @(posedge src_clk) begin
        if (hold)
            ready <= 1'b0;
        else if (rise_en)
            ready <= !(&pair_wait);
    end

endmodule

// File: rtl/clkgen_rst_sync.sv
`timescale 1ns/1ps
// Module clkgen_rst_sync
// Samples the active-low reset request through STAGES flops that advance
// on processor-clock rising edges. The reset output asserts as soon as the
// first stage sees the request low, and releases once every stage holds
// a high.
// Assumes STAGES >= 2 and that hold forces reset asserted.
module clkgen_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic hold,
    input  logic rise_en,
    input  logic req_n,
    output logic rst_out
);

    logic [STAGES-1:0] chain_q;

    // Synchronizer chain, one flop per stage.
    for (genvar gs = 0; gs < STAGES; gs++) begin : g_stage
        if (gs == 0) begin : g_first
            // First stage samples the raw request.
            always_ff @(posedge src_clk) begin
                if (hold)
                    chain_q[gs] <= 1'b0;
                else if (rise_en)
                    chain_q[gs] <= req_n;
            end
        end else begin : g_next
            // Later stages follow the previous stage.
            always_ff @(posedge src_clk) begin
                if (hold)
                    chain_q[gs] <= 1'b0;
                else if (rise_en)
                    chain_q[gs] <= chain_q[gs-1];
            end
        end
    end

    assign rst_out = !(&chain_q);

endmodule

// File: rtl/cpu_clkgen.sv
`timescale 1ns/1ps
// Module cpu_clkgen
// Top of the processor clock, ready and reset generator. It selects a
// source, divides it into a processor clock and a peripheral clock, and
// registers ready and reset on processor-clock rising edges.
// Assumes src_sel is changed only while csync is high, and that csync is
// high at power-up to bring every register to a known state.
module cpu_clkgen
    import clkgen_pkg::*;
#(
    parameter int CPU_DIV    = 3,
    parameter int CPU_HIGH   = 1,
    parameter int RDY_PAIRS  = 2,
    parameter int RST_STAGES = 2
) (
    input  logic clk_xtal,
    input  logic clk_ext,
    input  logic src_sel,
    input  logic csync,
    input  logic rdy_a,
    input  logic rdy_a_en_n,
    input  logic rdy_b,
    input  logic rdy_b_en_n,
    input  logic rst_req_n,
    output logic osc_out,
    output logic cpu_clk,
    output logic per_clk,
    output logic cpu_ready,
    output logic cpu_rst
);

    logic src_clk;
    logic cpu_rise;
    rdy_pair_t [RDY_PAIRS-1:0] pairs;

    // Gather the external pairs; any extra pairs are tied to "no wait".
    for (genvar gp = 0; gp < RDY_PAIRS; gp++) begin : g_pairs
        if (gp == 0) begin : g_a
            assign pairs[gp] = '{rdy: rdy_a, en_n: rdy_a_en_n};
        end else if (gp == 1) begin : g_b
            assign pairs[gp] = '{rdy: rdy_b, en_n: rdy_b_en_n};
        end else begin : g_tie
            assign pairs[gp] = '{rdy: 1'b1, en_n: 1'b0};
        end
    end

    clkgen_src_sel u_src (
        .clk_xtal (clk_xtal),
        .clk_ext  (clk_ext),
        .sel      (src_sel),
        .src_clk  (src_clk)
    );

    assign osc_out = src_clk;

    clkgen_div #(
        .DIV  (CPU_DIV),
        .HIGH (CPU_HIGH)
    ) u_cpu_div (
        .src_clk (src_clk),
        .hold    (csync),
        .clk_out (cpu_clk),
        .rise_en (cpu_rise)
    );

    clkgen_per u_per (
        .src_clk (src_clk),
        .hold    (csync),
        .rise_en (cpu_rise),
        .per_clk (per_clk)
    );

    clkgen_ready #(
        .NUM_PAIRS (RDY_PAIRS)
    ) u_ready (
        .src_clk (src_clk),
        .hold    (csync),
        .rise_en (cpu_rise),
        .pairs   (pairs),
        .ready   (cpu_ready)
    );

    clkgen_rst_sync #(
        .STAGES (RST_STAGES)
    ) u_rst (
        .src_clk (src_clk),
        .hold    (csync),
        .rise_en (cpu_rise),
        .req_n   (rst_req_n),
        .rst_out (cpu_rst)
    );

endmodule

// File: rtl/clkgen_chk.sv
`timescale 1ns/1ps
// Module clkgen_chk
// Assertion checker bound to cpu_clkgen. It is timed by the selected
// source and measures the runs of the divided clock with counters.
module clkgen_chk #(
    parameter int CPU_DIV  = 3,
    parameter int CPU_HIGH = 1
) (
    input logic src_clk,
    input logic csync,
    input logic rdy_a,
    input logic rdy_a_en_n,
    input logic rdy_b,
    input logic rdy_b_en_n,
    input logic rst_req_n,
    input logic cpu_clk,
    input logic per_clk,
    input logic cpu_ready,
    input logic cpu_rst
);

    logic [7:0] hi_run;
    logic [7:0] lo_run;
    logic       seen_fall;

    // Length of the current high and low runs of the processor clock.
    always_ff @(posedge src_clk) begin
        if (csync) begin
            hi_run    <= '0;
            lo_run    <= '0;
            seen_fall <= 1'b0;
        end else begin
            hi_run    <= cpu_clk ? ((hi_run == 8'hFF) ? hi_run : hi_run + 8'd1) : 8'd0;
            lo_run    <= !cpu_clk ? ((lo_run == 8'hFF) ? lo_run : lo_run + 8'd1) : 8'd0;
            seen_fall <= seen_fall || (!cpu_clk && (hi_run != 8'd0));
        end
    end

    // R2
    cpu_high_time_chk: assert property (@(posedge src_clk) disable iff (csync)
        $fell(cpu_clk) |-> (hi_run == 8'(CPU_HIGH)));

    // R2
    cpu_low_time_chk: assert property (@(posedge src_clk) disable iff (csync)
        ($rose(cpu_clk) && seen_fall) |-> (lo_run == 8'(CPU_DIV - CPU_HIGH)));

    // R3
    per_on_cpu_edge_chk: assert property (@(posedge src_clk) disable iff (csync)
        !$rose(cpu_clk) |-> $stable(per_clk));

    // R4
    sync_hold_chk: assert property (@(posedge src_clk)
        csync |=> (!cpu_clk && !per_clk && !cpu_ready && cpu_rst));

    // R5
    ready_value_chk: assert property (@(posedge src_clk) disable iff (csync)
        $rose(cpu_clk) |-> (cpu_ready == !((!$past(rdy_a) || $past(rdy_a_en_n)) &&
                                           (!$past(rdy_b) || $past(rdy_b_en_n)))));

    // R6
    ready_stable_chk: assert property (@(posedge src_clk) disable iff (csync)
        !$rose(cpu_clk) |-> $stable(cpu_ready));

    // R7
    rst_assert_chk: assert property (@(posedge src_clk) disable iff (csync)
        ($rose(cpu_clk) && !$past(rst_req_n)) |-> cpu_rst);

    // R8
    rst_release_edge_chk: assert property (@(posedge src_clk) disable iff (csync)
        $fell(cpu_rst) |-> $rose(cpu_clk));

endmodule

bind cpu_clkgen clkgen_chk #(
    .CPU_DIV  (CPU_DIV),
    .CPU_HIGH (CPU_HIGH)
) i_clkgen_chk (
    .src_clk    (src_clk),
    .csync      (csync),
    .rdy_a      (rdy_a),
    .rdy_a_en_n (rdy_a_en_n),
    .rdy_b      (rdy_b),
    .rdy_b_en_n (rdy_b_en_n),
    .rst_req_n  (rst_req_n),
    .cpu_clk    (cpu_clk),
    .per_clk    (per_clk),
    .cpu_ready  (cpu_ready),
    .cpu_rst    (cpu_rst)
);

// File: tb/test_cpu_clkgen.sv
`timescale 1ns/1ps
// Bench for cpu_clkgen: directed and seeded random stimulus, with expected
// values from bench functions.
module test_cpu_clkgen;

    logic clk_xtal = 1'b0;
    logic clk_ext  = 1'b0;
    logic src_sel, csync, rdy_a, rdy_a_en_n, rdy_b, rdy_b_en_n, rst_req_n;
    logic osc_out, cpu_clk, per_clk, cpu_ready, cpu_rst;

    int unsigned vectors     = 0;
    int unsigned miscompares = 0;
    logic [3:0]  cur_in      = 4'b0000; // {rdy_a, rdy_a_en_n, rdy_b, rdy_b_en_n}
    logic        cur_req     = 1'b1;
    logic [31:0] seed_word;

    always #10 clk_xtal = !clk_xtal;   // 50 MHz
    always #7  clk_ext  = !clk_ext;

    cpu_clkgen i_cpu_clkgen (
        .clk_xtal   (clk_xtal),
        .clk_ext    (clk_ext),
        .src_sel    (src_sel),
        .csync      (csync),
        .rdy_a      (rdy_a),
        .rdy_a_en_n (rdy_a_en_n),
        .rdy_b      (rdy_b),
        .rdy_b_en_n (rdy_b_en_n),
        .rst_req_n  (rst_req_n),
        .osc_out    (osc_out),
        .cpu_clk    (cpu_clk),
        .per_clk    (per_clk),
        .cpu_ready  (cpu_ready),
        .cpu_rst    (cpu_rst)
    );

    // R5 truth table: wait only when both pairs ask for one.
    function automatic logic exp_ready(logic [3:0] v);
        return !((!v[3] || v[2]) && (!v[1] || v[0]));
    endfunction

    // R2 and R3 waveforms, k counted from the first edge after sync release.
    function automatic logic exp_cpu(int k);
        return ((k - 1) % 3) == 0;
    endfunction

    function automatic logic exp_per(int k);
        return (((k - 1) / 3) % 2) == 0;
    endfunction

    task automatic check(string req, string what, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic apply_inputs();
        {rdy_a, rdy_a_en_n, rdy_b, rdy_b_en_n} = cur_in;
        rst_req_n = cur_req;
    endtask

    // One rising edge of the selected source, then 1 ns to let outputs settle.
    task automatic step();
        if (src_sel) @(posedge clk_ext);
        else         @(posedge clk_xtal);
        #1;
    endtask

    task automatic run(logic sel, int nsteps, bit directed);
        logic e_rdy, e_s1, e_s2, e_rst, rise;
        csync   = 1'b1;
        src_sel = sel;
        repeat (4) step();
        // R4 state while held
        check("R4", "cpu_clk held", cpu_clk, 1'b0);
        check("R4", "per_clk held", per_clk, 1'b0);
        check("R4", "cpu_ready held", cpu_ready, 1'b0);
        check("R4", "cpu_rst held", cpu_rst, 1'b1);
        // R1 source copy: high just after a rising edge, low after half a period
        check("R1", "osc_out high", osc_out, 1'b1);
        #(sel ? 7 : 10);
        check("R1", "osc_out low", osc_out, 1'b0);
        step();
        csync = 1'b0;
        e_rdy = 1'b0; e_s1 = 1'b0; e_s2 = 1'b0;
        for (int k = 1; k <= nsteps; k++) begin
            step();
            rise = exp_cpu(k);
            if (rise) begin
                e_rdy = exp_ready(cur_in);
                e_s2  = e_s1;
                e_s1  = cur_req;
            end
            e_rst = !(e_s1 && e_s2);
            check("R2", "cpu_clk", cpu_clk, exp_cpu(k));
            check("R3", "per_clk", per_clk, exp_per(k));
            if (rise) check("R5", "cpu_ready", cpu_ready, e_rdy);
            else      check("R6", "cpu_ready hold", cpu_ready, e_rdy);
            if (e_rst) check("R7", "cpu_rst", cpu_rst, e_rst);
            else       check("R8", "cpu_rst", cpu_rst, e_rst);
            if (directed) begin
                if (rise) begin
                    cur_in  = 4'((k - 1) / 3);
                    cur_req = !(((k - 1) / 3) == 6 || ((k - 1) / 3) == 7);
                end
            end else begin
                if (($urandom % 4) == 0)  cur_in  = 4'($urandom);
                if (($urandom % 12) == 0) cur_req = !cur_req;
            end
            apply_inputs();
        end
    endtask

    initial begin
        seed_word = $urandom(32'd20240611);
        csync   = 1'b1;
        src_sel = 1'b0;
        apply_inputs();
        run(1'b0, 48, 1'b1);
        run(1'b0, 360, 1'b0);
        run(1'b1, 48, 1'b1);
        run(1'b1, 360, 1'b0);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule